// File: doc/BRIEF.md
# Buffered Modulus Timebase Counter

This block is a shared timebase for a bank of timer channels. A 24-bit counter steps upward from 1 to a programmable modulus. On the tick where it sits at the modulus, it returns to 1. The current count, a one-cycle match pulse and a one-cycle boundary pulse go out to neighbouring channels, so they can line up their own compares with the period.

The modulus has two registers. Software writes a staging copy at any time. The active copy only takes the staging value on the tick that returns the counter to 1, so a new period starts cleanly at the end of the old one. The counter moves only when counting is enabled and a tick arrives. The tick source is either an internal prescaler or a chosen edge of an external pin, synchronized to the block clock. While counting is disabled, software may preload the count. A sticky match flag records that at least one modulus match has occurred.

Top module: `mod_timebase`

## Requirements
- R1: After reset the count reads 1. The active and staging modulus both hold all ones, and the sticky flag reads 0.
- R2: While `en_i` is high, each tick adds one to the count, starting from whatever value the count already holds. While `en_i` is low, the count holds its value unless a preload is written.
- R3: A tick that arrives while the count equals the active modulus loads the count with 1. In the cycle the count becomes 1, both `match_o` and `boundary_o` are high for exactly one cycle.
- R4: A write to address 0 loads only the staging modulus. A read of address 0 returns the active modulus. The active modulus copies the staging modulus only on a tick that loads the count with 1, and it uses the staging value held before any write in that same cycle.
- R5: If the count is above the active modulus, no match happens. The count rises to 0xFFFFFF, and the next tick loads 1 and swaps in the staging modulus. `boundary_o` pulses for one cycle and `match_o` stays low.
- R6: With `ext_sel_i` = 0, a tick is produced once every `psc_div_i`+1 enabled cycles. The prescaler restarts from zero whenever counting is disabled.
- R7: With `ext_sel_i` = 1, `pin_i` passes through two synchronizing flops. With `edge_both_i` = 0, each rising edge (`edge_pol_i` = 1) or each falling edge (`edge_pol_i` = 0) gives one tick. With `edge_both_i` = 1, every edge gives one tick and `edge_pol_i` is ignored.
- R8: A write to address 1 while `en_i` is low loads the count. A write to address 1 while `en_i` is high has no effect. A read of address 1 returns the count.
- R9: A match sets the sticky flag, which reads at address 2, bit 0. Writing 1 to bit 0 of address 2 clears the flag. If a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counting enable |
| ext_sel_i | input | 1 | Tick source: 0 selects the prescaler, 1 selects the pin |
| edge_both_i | input | 1 | When set, both pin edges count |
| edge_pol_i | input | 1 | Single-edge polarity: 1 selects rising, 0 selects falling |
| pin_i | input | 1 | External tick pin, asynchronous |
| psc_div_i | input | 8 | Prescaler divide value minus one |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 modulus, 1 count, 2 flag |
| wr_data_i | input | 24 | Write data |
| rd_addr_i | input | 2 | Read address, same map as writes |
| rd_data_o | output | 24 | Read data, combinational |
| count_o | output | 24 | Current count to neighbouring channels |
| match_o | output | 1 | One-cycle pulse when the count wraps on a modulus match |
| boundary_o | output | 1 | One-cycle pulse whenever the count is loaded with 1 by a tick |
| flag_o | output | 1 | Sticky match flag |

## Verification
The properties assume that `pin_i` holds each level for longer than the synchronizer delay and that `psc_div_i` and the edge controls change only while counting is disabled. The stimulus meets this by changing the pin only every four cycles and by setting the tick controls before raising `en_i`. The properties also assume that the active modulus is never 1. With a modulus of 1 the count never changes value, and a scoreboard that watches for changes in the count cannot see those steps, so the bench programs only moduli of 4 or more. No test writes the staging modulus in the same cycle as a boundary tick, so the order of a write and a swap in the same cycle is covered only by requirement R4 and not by a check.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
  typedef enum logic [1:0] {
    ADDR_MOD  = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_FLAG = 2'd2,
    ADDR_RSVD = 2'd3
  } mtb_addr_e;
endpackage

// File: rtl/mtb_tick_gen.sv
module mtb_tick_gen #(
  parameter int PSC_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ext_sel_i,
  input  logic             edge_both_i,
  input  logic             edge_pol_i,
  input  logic             pin_i,
  input  logic [PSC_W-1:0] psc_div_i,
  output logic             tick_o
);
  localparam int SR_W = SYNC_N + 1;

  logic [SR_W-1:0]  pin_sr_q;
  logic [PSC_W-1:0] psc_q;
  logic             rise, fall, ext_edge, int_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_sr_q <= '0;
    else         pin_sr_q <= {pin_sr_q[SR_W-2:0], pin_i};
  end

  // newest synchronized sample vs previous one
  assign rise = pin_sr_q[SR_W-2] & ~pin_sr_q[SR_W-1];
  assign fall = ~pin_sr_q[SR_W-2] & pin_sr_q[SR_W-1];

  always_comb begin
    if (edge_both_i)     ext_edge = rise | fall;
    else if (edge_pol_i) ext_edge = rise;
    else                 ext_edge = fall;
  end

  assign int_tick = (psc_q == psc_div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   psc_q <= '0;
    else if (!en_i || ext_sel_i)   psc_q <= '0;
    else if (int_tick)             psc_q <= '0;
    else                           psc_q <= psc_q + 1'b1;
  end

  assign tick_o = en_i & (ext_sel_i ? ext_edge : int_tick);
endmodule

// File: rtl/mtb_core.sv
module mtb_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             stg_wr_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_mod_o,
  output logic             match_o,
  output logic             boundary_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, act_q, stg_q;
  logic             match_q, bnd_q;
  logic             hit_mod, hit_max;

  assign hit_mod = (cnt_q == act_q);
  assign hit_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= CNT_ONE;
      act_q   <= CNT_MAX;
      stg_q   <= CNT_MAX;
      match_q <= 1'b0;
      bnd_q   <= 1'b0;
    end else begin
      match_q <= 1'b0;
      bnd_q   <= 1'b0;
      if (stg_wr_i) stg_q <= wr_data_i;
      if (tick_i) begin
        if (hit_mod || hit_max) begin
          cnt_q   <= CNT_ONE;
          act_q   <= stg_q;  // swap uses pre-write staging value
          bnd_q   <= 1'b1;
          match_q <= hit_mod;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cnt_wr_i && !en_i) begin
        cnt_q <= wr_data_i;
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign act_mod_o  = act_q;
  assign match_o    = match_q;
  assign boundary_o = bnd_q;
endmodule

// File: rtl/mod_timebase.sv
module mod_timebase #(
  parameter int CNT_W = 24,
  parameter int PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ext_sel_i,
  input  logic             edge_both_i,
  input  logic             edge_pol_i,
  input  logic             pin_i,
  input  logic [PSC_W-1:0] psc_div_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             match_o,
  output logic             boundary_o,
  output logic             flag_o
);
  import mtb_pkg::*;

  logic             tick_w;
  logic [CNT_W-1:0] act_mod_w;
  logic             flag_q, flag_clr;

  mtb_tick_gen #(.PSC_W(PSC_W), .SYNC_N(2)) i_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .ext_sel_i   (ext_sel_i),
    .edge_both_i (edge_both_i),
    .edge_pol_i  (edge_pol_i),
    .pin_i       (pin_i),
    .psc_div_i   (psc_div_i),
    .tick_o      (tick_w)
  );

  mtb_core #(.CNT_W(CNT_W)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tick_i     (tick_w),
    .stg_wr_i   (wr_en_i && (wr_addr_i == ADDR_MOD)),
    .cnt_wr_i   (wr_en_i && (wr_addr_i == ADDR_CNT)),
    .wr_data_i  (wr_data_i),
    .cnt_o      (count_o),
    .act_mod_o  (act_mod_w),
    .match_o    (match_o),
    .boundary_o (boundary_o)
  );

  assign flag_clr = wr_en_i && (wr_addr_i == ADDR_FLAG) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (match_o)  flag_q <= 1'b1;  // set wins
    else if (flag_clr) flag_q <= 1'b0;
  end

  // match_o rises together with the count reaching 1; flag follows one cycle later
  assign flag_o = flag_q;

  always_comb begin
    unique case (rd_addr_i)
      ADDR_MOD:  rd_data_o = act_mod_w;
      ADDR_CNT:  rd_data_o = count_o;
      ADDR_FLAG: rd_data_o = {{(CNT_W-1){1'b0}}, flag_q};
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/mtb_checker.sv
module mtb_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] act_i,
  input logic             match_i,
  input logic             bnd_i,
  input logic             flag_i
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i != act_i && cnt_i != CMAX) |=> (cnt_i == $past(cnt_i) + 1'b1));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !(wr_en_i && wr_addr_i == 2'd1)) |=> $stable(cnt_i));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == act_i) |=> (cnt_i == 1 && match_i && bnd_i));

  p_bnd_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_i |-> (cnt_i == 1));

  p_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> !match_i);

  p_swap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_i |-> $stable(act_i));

  p_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == CMAX && cnt_i != act_i) |=> (cnt_i == 1 && bnd_i && !match_i));

  p_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> flag_i);
endmodule

bind mod_timebase mtb_checker #(.CNT_W(CNT_W)) i_mtb_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .tick_i    (tick_w),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .cnt_i     (count_o),
  .act_i     (act_mod_w),
  .match_i   (match_o),
  .bnd_i     (boundary_o),
  .flag_i    (flag_o)
);

// File: tb/test_mod_timebase.sv
module test_mod_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 24;
  localparam int PW = 8;
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, ext_sel = 0, both = 0, pol = 1, pin = 0;
  logic [PW-1:0] psc = '0;
  logic wr_en = 0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] rd_data, count;
  logic match, bnd, flag;

  int n_chk = 0, n_err = 0;
  int n_match_seen = 0, n_bnd_seen = 0;
  int m_match = 0, m_bnd = 0;
  logic [CW-1:0] m_cnt, m_act, m_stg, prev_cnt;
  logic [CW-1:0] exp_q[$];
  string         tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mod_timebase #(.CNT_W(CW), .PSC_W(PW)) i_mod_timebase (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ext_sel_i(ext_sel),
    .edge_both_i(both), .edge_pol_i(pol), .pin_i(pin), .psc_div_i(psc),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .count_o(count),
    .match_o(match), .boundary_o(bnd), .flag_o(flag)
  );

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model step per requirements R2, R3, R4, R5
  task automatic step(input string tag);
    if (m_cnt == m_act || m_cnt == MAXV) begin
      if (m_cnt == m_act) m_match++;
      m_bnd++;
      m_cnt = 1;
      m_act = m_stg;
    end else begin
      m_cnt = m_cnt + 1'b1;
    end
    exp_q.push_back(m_cnt);
    tag_q.push_back(tag);
  endtask

  // monitor: compare every count change against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (match) n_match_seen++;
      if (bnd)   n_bnd_seen++;
      if (count !== prev_cnt) begin
        if (exp_q.size() == 0) check("R2 unexpected count change", count, prev_cnt);
        else check(tag_q.pop_front(), count, exp_q.pop_front());
      end
      prev_cnt = count;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [CW-1:0] exp, input string tag);
    @(negedge clk); rd_addr = a; #1;
    check(tag, rd_data, exp);
  endtask

  task automatic run(input int cycles, input int ticks, input string tag);
    for (int i = 0; i < ticks; i++) step(tag);
    @(negedge clk); en = 1;
    repeat (cycles) @(negedge clk);
    en = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic toggle(input logic v, input logic counts, input string tag);
    @(negedge clk);
    if (counts) step(tag);
    pin = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    m_cnt = 1; m_act = MAXV; m_stg = MAXV; prev_cnt = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 count", count, 24'd1);
    rd_chk(2'd0, MAXV, "R1 active modulus");
    rd_chk(2'd2, 24'd0, "R1 flag");

    wr(2'd0, 24'd4); m_stg = 4;
    rd_chk(2'd0, MAXV, "R4 read returns active");
    exp_q.push_back(24'hFFFFFE); tag_q.push_back("R8 preload");
    wr(2'd1, 24'hFFFFFE); m_cnt = 24'hFFFFFE;
    run(8, 8, "R3 wrap");
    rd_chk(2'd0, 24'd4, "R4 swap at boundary");
    check("R3 match pulses", 24'(n_match_seen), 24'(m_match));
    rd_chk(2'd2, 24'd1, "R9 flag set");

    wr(2'd0, 24'd6); m_stg = 6;
    rd_chk(2'd0, 24'd4, "R4 no swap mid-period");
    run(3, 3, "R4 swap");
    rd_chk(2'd0, 24'd6, "R4 new modulus");

    // preload while enabled is ignored
    step("R8 ignored preload");
    step("R8 ignored preload");
    @(negedge clk); en = 1; wr_en = 1; wr_addr = 2'd1; wr_data = 24'd100;
    @(negedge clk); wr_en = 0;
    @(negedge clk); en = 0;
    repeat (2) @(negedge clk);
    rd_chk(2'd1, m_cnt, "R8 count readback");

    // above-modulus overflow
    exp_q.push_back(24'hFFFFFD); tag_q.push_back("R8 preload");
    wr(2'd1, 24'hFFFFFD); m_cnt = 24'hFFFFFD;
    run(3, 3, "R5 overflow");
    check("R5 no match", 24'(n_match_seen), 24'(m_match));
    check("R5 boundary", 24'(n_bnd_seen), 24'(m_bnd));
    run(6, 6, "R3 resume");

    // hold while disabled
    repeat (10) @(negedge clk);
    check("R2 hold", count, m_cnt);

    // prescaler: divide by 3
    psc = 8'd2;
    run(9, 3, "R6 prescaler");
    psc = 8'd0;

    // external edges
    ext_sel = 1; both = 0; pol = 1;
    @(negedge clk); en = 1;
    toggle(1, 1, "R7 rising");
    toggle(0, 0, "R7 rising");
    toggle(1, 1, "R7 rising");
    pol = 0;
    toggle(0, 1, "R7 falling");
    toggle(1, 0, "R7 falling");
    both = 1;
    toggle(0, 1, "R7 both");
    toggle(1, 1, "R7 both");
    @(negedge clk); en = 0; ext_sel = 0;
    repeat (3) @(negedge clk);
    check("R7 count", count, m_cnt);

    wr(2'd2, 24'd0);
    rd_chk(2'd2, 24'd1, "R9 zero write keeps flag");
    wr(2'd2, 24'd1);
    rd_chk(2'd2, 24'd0, "R9 W1C");

    check("R3 total matches", 24'(n_match_seen), 24'(m_match));
    check("R3 total boundaries", 24'(n_bnd_seen), 24'(m_bnd));
    check("R2 scoreboard drained", 24'(exp_q.size()), 24'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule